// File: doc/BRIEF.md
# TLB-Backed Page Translator

This block turns a logical address into a physical address under single-level paging. The upper bits of the logical address form the page number and the lower bits form the offset within the page. A small fully associative translation cache is compared against the page number, every entry at once. On a match, the frame number comes straight from the cache and no page-table read takes place. The physical address is the frame number joined to the unchanged offset, so no adder is involved.

When the cache misses, the block issues a single read on its memory port. The address of that read is the page-table base plus the page number. The returned page-table entry is checked for validity and write permission. If the entry is good, it is installed in the cache in round-robin order and the translation completes. Before any lookup, a page number at or beyond the table length is rejected.

A flush input empties the cache in one cycle and is meant to be raised when the running process changes. Two counters tally hits and misses so that software can compute the hit ratio.

Top module: `page_xlate_top`

## Requirements
- R1: After reset, `resp_valid` and `mem_rd_en` are 0, `req_ready` is 1, and both counters read 0.
- R2: A successful translation returns `resp_paddr` = {frame, offset}, where offset is the low OFF_W bits of the request address, passed through unchanged.
- R3: A request whose page is cached produces `resp_valid` with `resp_hit`=1 in the cycle after acceptance. It issues no memory read, and `hit_count` rises by one.
- R4: A request that misses drives `mem_rd_en` high for exactly one cycle, in the cycle after acceptance, at address `pt_base` + page number, and `miss_count` rises by one. The response, with `resp_hit`=0, is registered on the same clock edge that samples `mem_rd_valid`.
- R5: A page number greater than or equal to `pt_len` yields a response in the next cycle with fault code 1 and `resp_paddr`=0. It makes no memory read and changes neither counter. This check comes before the cache lookup.
- R6: A page-table entry holds the valid flag in bit 0, the read-only flag in bit 1, and the frame number in bits FRAME_W+1 down to 2. A clear valid flag gives fault code 2 and `resp_paddr`=0.
- R7: A write to a read-only page gives fault code 3 and `resp_paddr`=0, whether the page was found in the cache or in the table. A read of a read-only page succeeds. Fault code 0 means no fault.
- R8: An entry that caused a fault is not cached, so the same page misses again on its next request.
- R9: A successful miss installs its entry in the cache. Slots are replaced in round-robin order, so with TLB_N slots, the (TLB_N+1)-th distinct fill evicts the first.
- R10: While `flush` is high, `req_ready` is 0 and no request is taken. After a flush, every page misses.
- R11: `req_ready` stays 0 from the acceptance of a missing request until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write access |
| req_vaddr | input | VA_W | Logical address |
| req_ready | output | 1 | Block can accept a request |
| pt_base | input | PT_ADDR_W | Page-table base address (in entry units) |
| pt_len | input | VA_W-OFF_W+1 | Number of entries in the page table |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | PT_ADDR_W | Page-table read address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | FRAME_W+2 | Page-table entry |
| resp_valid | output | 1 | Translation result present (one cycle) |
| resp_hit | output | 1 | Result came from the cache |
| resp_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 read-only |
| resp_paddr | output | FRAME_W+OFF_W | Physical address, 0 on fault |
| hit_count | output | CNT_W | Cache hits since reset |
| miss_count | output | CNT_W | Cache misses since reset |

## Verification
The bench targets the boundary page number equal to the table length, which an off-by-one compare would translate instead of rejecting. It also checks that a shrunken table rejects a page that is still cached, which a design that looks in the cache first would wrongly translate. A write to a read-only page is tried both from the cache and from memory, to catch a design that forgets the cached permission bit, and faulting pages are requested twice to expose any that cache them. Round-robin eviction is checked by filling one page more than the cache holds and finding exactly the oldest page gone. Flush is checked both for blocking requests and for emptying the cache.

// File: rtl/page_xlate_pkg.sv
`timescale 1ns/1ps
package page_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_LENGTH   = 2'd1,
        FLT_INVALID  = 2'd2,
        FLT_READONLY = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;

    // Page-table entry layout
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_RO_BIT    = 1;
    localparam int PTE_FRAME_LSB = 2;

    // Permission outcome shared by cache-hit and table-read paths
    function automatic fault_e perm_fault(input logic valid, input logic ro, input logic wr);
        if (!valid)
            return FLT_INVALID;
        else if (ro && wr)
            return FLT_READONLY;
        else
            return FLT_NONE;
    endfunction

endpackage

// File: rtl/event_counter.sv
`timescale 1ns/1ps
module event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // R3 / R4: each counted event advances the tally by exactly one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        inc |=> (count == $past(count) + 1'b1));

    assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));

endmodule

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam #(
    parameter int VPN_W   = 8,
    parameter int FRAME_W = 8,
    parameter int N       = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               lk_ro,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_ro
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]       valid_q;
    logic [VPN_W-1:0]   vpn_q   [N];
    logic [FRAME_W-1:0] frame_q [N];
    logic [N-1:0]       ro_q;
    logic [IDX_W-1:0]   ptr_q;
    logic [N-1:0]       match;

    // Parallel compare, one comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_frame = '0;
        lk_ro    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                lk_hit   = 1'b1;
                lk_frame = lk_frame | frame_q[i];
                lk_ro    = lk_ro | ro_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            ro_q    <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < N; i++) begin
                vpn_q[i]   <= '0;
                frame_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            vpn_q[ptr_q]   <= fill_vpn;
            frame_q[ptr_q] <= fill_frame;
            ro_q[ptr_q]    <= fill_ro;
            ptr_q          <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R9: fills only follow misses, so no page occupies two slots
    assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    // R10: after a flush cycle no slot is usable
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R9: a fill (not overridden by flush) is visible on the next lookup of that page
    assert_fill_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush) |=> (valid_q != '0));

endmodule

// File: rtl/pte_check.sv
`timescale 1ns/1ps
module pte_check
    import page_xlate_pkg::*;
#(
    parameter int FRAME_W = 8,
    localparam int PTE_W = FRAME_W + 2
) (
    input  logic [PTE_W-1:0]   pte,
    input  logic               is_write,
    output fault_e             fault,
    output logic [FRAME_W-1:0] frame,
    output logic               ro
);
    assign frame = pte[PTE_FRAME_LSB +: FRAME_W];
    assign ro    = pte[PTE_RO_BIT];
    assign fault = perm_fault(pte[PTE_VALID_BIT], pte[PTE_RO_BIT], is_write);
endmodule

// File: rtl/xlate_ctrl.sv
`timescale 1ns/1ps
module xlate_ctrl
    import page_xlate_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int OFF_W     = 8,
    parameter int FRAME_W   = 8,
    parameter int PT_ADDR_W = 16,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int LEN_W = VPN_W + 1,
    localparam int PA_W  = FRAME_W + OFF_W,
    localparam int PTE_W = FRAME_W + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [VA_W-1:0]      req_vaddr,
    output logic                 req_ready,
    input  logic [PT_ADDR_W-1:0] pt_base,
    input  logic [LEN_W-1:0]     pt_len,
    output logic [VPN_W-1:0]     lk_vpn,
    input  logic                 lk_hit,
    input  logic [FRAME_W-1:0]   lk_frame,
    input  logic                 lk_ro,
    output logic                 fill_en,
    output logic [VPN_W-1:0]     fill_vpn,
    output logic [FRAME_W-1:0]   fill_frame,
    output logic                 fill_ro,
    output logic                 mem_rd_en,
    output logic [PT_ADDR_W-1:0] mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [PTE_W-1:0]     mem_rd_data,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output fault_e               resp_fault,
    output logic [PA_W-1:0]      resp_paddr,
    output logic                 hit_inc,
    output logic                 miss_inc
);
    xl_state_e          state_q;
    logic [VPN_W-1:0]   vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic               wr_q;

    logic               accept;
    logic               len_bad;
    logic [VPN_W-1:0]   req_vpn;
    logic [OFF_W-1:0]   req_off;
    fault_e             hit_fault;
    fault_e             pte_fault;
    logic [FRAME_W-1:0] pte_frame;
    logic               pte_ro;

    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign req_ready = (state_q == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign len_bad   = ({1'b0, req_vpn} >= pt_len);
    assign lk_vpn    = req_vpn;
    assign hit_fault = perm_fault(1'b1, lk_ro, req_write);

    assign hit_inc  = accept && !len_bad && lk_hit;
    assign miss_inc = accept && !len_bad && !lk_hit;

    pte_check #(.FRAME_W(FRAME_W)) u_chk (
        .pte      (mem_rd_data),
        .is_write (wr_q),
        .fault    (pte_fault),
        .frame    (pte_frame),
        .ro       (pte_ro)
    );

    assign mem_rd_en   = (state_q == ST_FETCH);
    assign mem_rd_addr = pt_base + PT_ADDR_W'(vpn_q);

    assign fill_en    = (state_q == ST_WAIT) && mem_rd_valid && (pte_fault == FLT_NONE);
    assign fill_vpn   = vpn_q;
    assign fill_frame = pte_frame;
    assign fill_ro    = pte_ro;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            vpn_q      <= '0;
            off_q      <= '0;
            wr_q       <= 1'b0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= FLT_NONE;
            resp_paddr <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        vpn_q <= req_vpn;
                        off_q <= req_off;
                        wr_q  <= req_write;
                        if (len_bad) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b0;
                            resp_fault <= FLT_LENGTH;
                            resp_paddr <= '0;
                        end else if (lk_hit) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_fault <= hit_fault;
                            resp_paddr <= (hit_fault == FLT_NONE) ? {lk_frame, req_off} : '0;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        state_q    <= ST_IDLE;
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_fault <= pte_fault;
                        resp_paddr <= (pte_fault == FLT_NONE) ? {pte_frame, off_q} : '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: out-of-range page answered next cycle with a length fault
    assert_len_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && len_bad) |=> (resp_valid && resp_fault == FLT_LENGTH && resp_paddr == '0));

    // R3: a cache hit answers in the following cycle
    assert_hit_latency_R3: assert property (@(posedge clk) disable iff (rst)
        hit_inc |=> (resp_valid && resp_hit));

    // R4: the table read strobe lasts a single cycle
    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R11: a miss holds off further requests
    assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
        miss_inc |=> !req_ready);

    // R2: successful results keep the accepted offset
    assert_offset_R2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault == FLT_NONE) |-> (resp_paddr[OFF_W-1:0] == off_q));

endmodule

// File: rtl/page_xlate_top.sv
`timescale 1ns/1ps
module page_xlate_top
    import page_xlate_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int OFF_W     = 8,
    parameter int FRAME_W   = 8,
    parameter int TLB_N     = 4,
    parameter int PT_ADDR_W = 16,
    parameter int CNT_W     = 16,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int LEN_W = VPN_W + 1,
    localparam int PA_W  = FRAME_W + OFF_W,
    localparam int PTE_W = FRAME_W + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [VA_W-1:0]      req_vaddr,
    output logic                 req_ready,
    input  logic [PT_ADDR_W-1:0] pt_base,
    input  logic [LEN_W-1:0]     pt_len,
    output logic                 mem_rd_en,
    output logic [PT_ADDR_W-1:0] mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [PTE_W-1:0]     mem_rd_data,
    output logic                 resp_valid,
    output logic                 resp_hit,
    output logic [1:0]           resp_fault,
    output logic [PA_W-1:0]      resp_paddr,
    output logic [CNT_W-1:0]     hit_count,
    output logic [CNT_W-1:0]     miss_count
);
    logic [VPN_W-1:0]   lk_vpn;
    logic               lk_hit;
    logic [FRAME_W-1:0] lk_frame;
    logic               lk_ro;
    logic               fill_en;
    logic [VPN_W-1:0]   fill_vpn;
    logic [FRAME_W-1:0] fill_frame;
    logic               fill_ro;
    logic               hit_inc;
    logic               miss_inc;
    fault_e             fault_w;

    tlb_cam #(.VPN_W(VPN_W), .FRAME_W(FRAME_W), .N(TLB_N)) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .lk_vpn     (lk_vpn),
        .lk_hit     (lk_hit),
        .lk_frame   (lk_frame),
        .lk_ro      (lk_ro),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_frame (fill_frame),
        .fill_ro    (fill_ro)
    );

    xlate_ctrl #(
        .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .PT_ADDR_W(PT_ADDR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_vaddr    (req_vaddr),
        .req_ready    (req_ready),
        .pt_base      (pt_base),
        .pt_len       (pt_len),
        .lk_vpn       (lk_vpn),
        .lk_hit       (lk_hit),
        .lk_frame     (lk_frame),
        .lk_ro        (lk_ro),
        .fill_en      (fill_en),
        .fill_vpn     (fill_vpn),
        .fill_frame   (fill_frame),
        .fill_ro      (fill_ro),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .resp_valid   (resp_valid),
        .resp_hit     (resp_hit),
        .resp_fault   (fault_w),
        .resp_paddr   (resp_paddr),
        .hit_inc      (hit_inc),
        .miss_inc     (miss_inc)
    );

    assign resp_fault = fault_w;

    event_counter #(.W(CNT_W)) u_hits (
        .clk(clk), .rst(rst), .inc(hit_inc), .count(hit_count)
    );

    event_counter #(.W(CNT_W)) u_misses (
        .clk(clk), .rst(rst), .inc(miss_inc), .count(miss_count)
    );

    // R1: nothing is reported or requested straight out of reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!resp_valid && !mem_rd_en));

endmodule

// File: tb/sim_page_xlate_top.sv
`timescale 1ns/1ps
module sim_page_xlate_top;

    localparam logic [15:0] PT_BASE = 16'h1000;
    localparam int NVEC = 21;

    // {write, vpn, offset, expect_hit, expect_fault}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 8'd1,   8'h34, 1'b0, 2'd0},  // miss, fill
        {1'b0, 8'd1,   8'h00, 1'b1, 2'd0},  // hit
        {1'b1, 8'd1,   8'hFF, 1'b1, 2'd0},  // write hit, writable
        {1'b0, 8'd3,   8'h11, 1'b0, 2'd2},  // invalid entry
        {1'b0, 8'd3,   8'h12, 1'b0, 2'd2},  // still a miss (not cached)
        {1'b0, 8'd2,   8'h21, 1'b0, 2'd0},  // read of read-only page
        {1'b1, 8'd2,   8'h22, 1'b1, 2'd3},  // write, read-only from cache
        {1'b1, 8'd7,   8'h70, 1'b0, 2'd3},  // write, read-only from table
        {1'b0, 8'd7,   8'h71, 1'b0, 2'd0},  // miss again then fill
        {1'b0, 8'd250, 8'h01, 1'b0, 2'd1},  // beyond length
        {1'b0, 8'd200, 8'h02, 1'b0, 2'd1},  // equal to length
        {1'b0, 8'd199, 8'h03, 1'b0, 2'd2},  // last legal page, invalid
        {1'b0, 8'd198, 8'h04, 1'b0, 2'd0},  // fills fourth slot
        {1'b0, 8'd0,   8'h05, 1'b0, 2'd0},  // evicts page 1
        {1'b0, 8'd2,   8'h06, 1'b1, 2'd0},
        {1'b0, 8'd7,   8'h07, 1'b1, 2'd0},
        {1'b0, 8'd198, 8'h08, 1'b1, 2'd0},
        {1'b0, 8'd0,   8'h09, 1'b1, 2'd0},
        {1'b0, 8'd1,   8'h0A, 1'b0, 2'd0},  // evicted earlier, evicts page 2
        {1'b0, 8'd2,   8'h0B, 1'b0, 2'd0},  // evicts page 7
        {1'b0, 8'd198, 8'h0C, 1'b1, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        req_ready;
    logic [15:0] pt_base = PT_BASE;
    logic [8:0]  pt_len = 9'd200;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [9:0]  mem_rd_data = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [1:0]  resp_fault;
    logic [15:0] resp_paddr;
    logic [15:0] hit_count;
    logic [15:0] miss_count;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    page_xlate_top u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .pt_base(pt_base), .pt_len(pt_len),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .hit_count(hit_count), .miss_count(miss_count)
    );

    // Page-table contents: frame = vpn ^ A5, bit1 read-only, bit0 valid
    function automatic logic [9:0] pte_of(input logic [7:0] v);
        logic val;
        logic ro;
        val = ((v % 7) != 3);
        ro  = ((v % 5) == 2);
        return {v ^ 8'hA5, ro, val};
    endfunction

    // Memory model: answers two negedges after seeing a read strobe
    int          mem_cnt = 0;
    logic [15:0] mem_addr_q = '0;
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_cnt != 0) begin
            mem_cnt <= mem_cnt - 1;
            if (mem_cnt == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= pte_of(8'(mem_addr_q - PT_BASE));
            end
        end
        if (mem_rd_en) begin
            mem_cnt    <= 2;
            mem_addr_q <= mem_rd_addr;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [7:0] vpn, input logic [7:0] off,
                          input logic exp_hit, input logic [1:0] exp_fault, input string tag);
        int cyc;
        int nrd;
        int rdcyc;
        int mvcyc;
        logic [15:0] rdaddr;
        logic        busy_ok;
        logic [15:0] exp_pa;
        logic [9:0]  p;
        cyc = 1; nrd = 0; rdcyc = 0; mvcyc = -1; rdaddr = '0; busy_ok = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R11 ready idle"}, req_ready, 1);
        req_valid = 1'b1;
        req_write = wr;
        req_vaddr = {vpn, off};
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (mem_rd_en) begin
                nrd = nrd + 1;
                rdcyc = cyc;
                rdaddr = mem_rd_addr;
                if (req_ready) busy_ok = 1'b0;
            end
            if (mem_rd_valid) mvcyc = cyc;
            if (resp_valid || cyc > 60) break;
            @(negedge clk);
            cyc = cyc + 1;
        end
        p = pte_of(vpn);
        exp_pa = (exp_fault == 2'd0) ? {p[9:2], off} : 16'h0000;
        chk(resp_valid == 1'b1, {tag, " response seen"}, resp_valid, 1);
        chk(resp_fault == exp_fault, {tag, " R5/R6/R7 fault code"}, resp_fault, exp_fault);
        chk(resp_paddr == exp_pa, {tag, " R2 physical address"}, resp_paddr, exp_pa);
        chk(resp_hit == exp_hit, {tag, " R3/R4 hit flag"}, resp_hit, exp_hit);
        if (exp_hit || exp_fault == 2'd1) begin
            chk(cyc == 1, {tag, " R3 one-cycle answer"}, cyc, 1);
            chk(nrd == 0, {tag, " R3 no table read"}, nrd, 0);
        end else begin
            chk(nrd == 1 && rdcyc == 1, {tag, " R4 single read strobe"}, nrd, 1);
            chk(rdaddr == PT_BASE + 16'(vpn), {tag, " R4 read address"}, rdaddr, PT_BASE + 16'(vpn));
            chk(cyc == mvcyc, {tag, " R4 answer timing"}, cyc, mvcyc);
            chk(busy_ok, {tag, " R11 busy during miss"}, busy_ok, 1);
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, {tag, " single-cycle response"}, resp_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(resp_valid == 1'b0, "R1 resp_valid", resp_valid, 0);
        chk(mem_rd_en == 1'b0, "R1 mem_rd_en", mem_rd_en, 0);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(hit_count == 0 && miss_count == 0, "R1 counters", {hit_count, miss_count}, 0);

        // Table walk: R2..R9
        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] v;
            v = VEC[i];
            do_req(v[19], v[18:11], v[10:3], v[2], v[1:0], $sformatf("vec%0d R8 R9", i));
        end
        chk(hit_count == 16'd8, "R3 hit tally", hit_count, 8);
        chk(miss_count == 16'd11, "R4 miss tally (length faults uncounted, R5)", miss_count, 11);

        // R10: flush blocks requests and empties the cache
        @(negedge clk);
        flush = 1'b1;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_vaddr = {8'd198, 8'h00};
        #0.1;
        chk(req_ready == 1'b0, "R10 not ready during flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
        req_valid = 1'b0;
        chk(resp_valid == 1'b0 && mem_rd_en == 1'b0, "R10 request ignored during flush",
            {resp_valid, mem_rd_en}, 0);
        @(negedge clk);
        chk(resp_valid == 1'b0 && mem_rd_en == 1'b0, "R10 still idle after flush",
            {resp_valid, mem_rd_en}, 0);
        do_req(1'b0, 8'd198, 8'h5A, 1'b0, 2'd0, "R10 post-flush miss");
        do_req(1'b0, 8'd198, 8'h5B, 1'b1, 2'd0, "R10 refilled hit");

        // R5: length rejects a cached page before the lookup
        pt_len = 9'd198;
        do_req(1'b0, 8'd198, 8'h5C, 1'b0, 2'd1, "R5 shrunken table");
        do_req(1'b0, 8'd197, 8'h5D, 1'b0, 2'd0, "R5 last legal page");
        chk(hit_count == 16'd9, "R5 hit tally", hit_count, 9);
        chk(miss_count == 16'd13, "R5 miss tally", miss_count, 13);

        summary();
        $finish;
    end

endmodule